// File: doc/BRIEF.md
# Return Address Stack Predictor

This block predicts the targets of subroutine returns in the fetch stage. When fetch sees a call, the block computes the address of the instruction after the call (call PC plus instruction size) and pushes it onto a small fixed-depth stack. When fetch sees a return, the block offers the top entry as the predicted target in the same cycle and pops it on the next clock edge. The same routine can be entered from several call sites, and each return goes back to the site that made the call.

The stack is a circular buffer. When a call arrives and the stack is full, the oldest entry is overwritten. The return that owned that entry will later be mispredicted, and no error is raised for it. A return always pops the top entry blindly. The stack does not search for a matching entry, so a wrong push or pop leaves it out of step until the contents line up again. Any cycle that carries a call or a return also raises a flag that tells the direction and target tables not to record that instruction.

Top module: `ras_predictor`

## Requirements
- R1: After reset the stack is empty: a return strobe with no earlier call gives `pred_valid_o` = 0.
- R2: A call pushes `call_pc_i + insn_len_i`, computed modulo 2^ADDR_W, so the sum wraps at the top of the address space.
- R3: A return on a non-empty stack gives `pred_valid_o` = 1 and `pred_target_o` = the most recently pushed address that has not yet been popped, in the same cycle as the strobe. The entry is removed on the next rising clock edge, so entries come back in last-in-first-out order.
- R4: A return on an empty stack gives `pred_valid_o` = 0 and leaves the stack unchanged. A later call followed by a return predicts that call's address.
- R5: A call on a full stack (DEPTH entries) discards the oldest entry. After DEPTH+k calls, DEPTH returns predict the newest DEPTH addresses newest-first, and the next return gives `pred_valid_o` = 0.
- R6: A call and a return in the same cycle on a non-empty stack predict the old top entry and replace it with the new return address, leaving the depth unchanged. On an empty stack the pair acts as a plain call, with `pred_valid_o` = 0.
- R7: `skip_update_o` = 1 exactly in cycles where `call_i` or `ret_i` is 1.
- R8: The number of held entries never exceeds DEPTH.
- R9: `pred_valid_o` = 0 in any cycle without `ret_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| call_i | input | 1 | Call detected this cycle |
| ret_i | input | 1 | Return detected this cycle |
| call_pc_i | input | ADDR_W | PC of the call instruction |
| insn_len_i | input | LEN_W | Size of the call instruction in bytes |
| pred_valid_o | output | 1 | Return prediction is valid |
| pred_target_o | output | ADDR_W | Predicted return target |
| skip_update_o | output | 1 | Do not write this instruction into the history/target tables |

## Verification
Two situations are hard to reach from the ports. The first is the wrap of the circular buffer after overflow, followed by a full drain: the oldest slot is overwritten while the pointer crosses its boundary. The second is a same-cycle call and return at the edges, on an empty stack and on a full stack. Directed sequences push DEPTH+3 addresses and then pop until the stack is empty, and they issue call/return pairs at zero and at full depth. A long random run, weighted toward calls in its first phase and toward returns in its second, then crosses the full and empty boundaries many times, with each result compared against a bounded queue model in the bench.

// File: rtl/ras_pkg.sv
package ras_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_SWAP = 2'd3
  } ras_op_e;
endpackage

// File: rtl/ras_ptr_ctrl.sv
module ras_ptr_ctrl import ras_pkg::*; #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             call_i,
  input  logic             ret_i,
  output logic             empty_o,
  output logic             we_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [IDX_W-1:0] top_idx_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [IDX_W-1:0] top_q, top_inc, top_dec;
  logic [CNT_W-1:0] cnt_q;
  ras_op_e          op;

  assign empty_o = (cnt_q == '0);
  assign top_inc = (top_q == LAST_IDX) ? '0 : top_q + 1'b1;
  assign top_dec = (top_q == '0) ? LAST_IDX : top_q - 1'b1;

  always_comb begin
    op = OP_IDLE;
    if (call_i && ret_i) op = empty_o ? OP_PUSH : OP_SWAP;
    else if (call_i)     op = OP_PUSH;
    else if (ret_i && !empty_o) op = OP_POP;
  end

  assign we_o      = (op == OP_PUSH) || (op == OP_SWAP);
  assign wr_idx_o  = (op == OP_SWAP) ? top_q : top_inc;
  assign top_idx_o = top_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      top_q <= LAST_IDX;
      cnt_q <= '0;
    end else begin
      case (op)
        OP_PUSH: begin
          top_q <= top_inc;
          if (cnt_q != FULL_CNT) cnt_q <= cnt_q + 1'b1;
        end
        OP_POP: begin
          top_q <= top_dec;
          cnt_q <= cnt_q - 1'b1;
        end
        default: ;
      endcase
    end
  end

  a_r8_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL_CNT);
  a_r4_empty_pop_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !call_i && empty_o) |=> ($stable(cnt_q) && $stable(top_q)));
  a_r5_full_push_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && !ret_i && cnt_q == FULL_CNT) |=> (cnt_q == FULL_CNT));
  a_r6_swap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && ret_i && !empty_o) |=> ($stable(cnt_q) && $stable(top_q)));
  a_r3_pop_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !call_i && !empty_o) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/ras_storage.sv
module ras_storage #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [ADDR_W-1:0] rd_data_o
);
  logic [ADDR_W-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                slot_q[g] <= '0;
      else if (we_i && wr_idx_i == IDX_W'(g))     slot_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = slot_q[rd_idx_i];
endmodule

// File: rtl/ras_predictor.sv
module ras_predictor #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 8,
  parameter int LEN_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic [ADDR_W-1:0] call_pc_i,
  input  logic [LEN_W-1:0]  insn_len_i,
  output logic              pred_valid_o,
  output logic [ADDR_W-1:0] pred_target_o,
  output logic              skip_update_o
);
  localparam int IDX_W = $clog2(DEPTH);

  logic             empty, we;
  logic [IDX_W-1:0] wr_idx, top_idx;
  logic [ADDR_W-1:0] ret_addr;

  assign ret_addr = call_pc_i + ADDR_W'(insn_len_i);

  ras_ptr_ctrl #(.DEPTH(DEPTH)) ptr_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .call_i   (call_i),
    .ret_i    (ret_i),
    .empty_o  (empty),
    .we_o     (we),
    .wr_idx_o (wr_idx),
    .top_idx_o(top_idx)
  );

  ras_storage #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) mem_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (we),
    .wr_idx_i (wr_idx),
    .wr_data_i(ret_addr),
    .rd_idx_i (top_idx),
    .rd_data_o(pred_target_o)
  );

  assign pred_valid_o  = ret_i && !empty;
  assign skip_update_o = call_i || ret_i;

  a_r7_skip_covers_pred: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_valid_o |-> skip_update_o);
  a_r9_valid_needs_ret: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ret_i |-> !pred_valid_o);
  a_r2_push_fills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_i |=> !empty);
endmodule

// File: tb/ras_predictor_tb_top.sv
module ras_predictor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int DEPTH  = 8;
  localparam int LEN_W  = 3;
  localparam int WATCHDOG = 100000;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              call_i = 1'b0, ret_i = 1'b0;
  logic [ADDR_W-1:0] call_pc_i = '0;
  logic [LEN_W-1:0]  insn_len_i = '0;
  logic              pred_valid_o, skip_update_o;
  logic [ADDR_W-1:0] pred_target_o;

  int n_checks = 0, n_fail = 0, cycles = 0;
  logic [ADDR_W-1:0] model_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ras_predictor #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .LEN_W(LEN_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .call_i(call_i), .ret_i(ret_i),
    .call_pc_i(call_pc_i), .insn_len_i(insn_len_i),
    .pred_valid_o(pred_valid_o), .pred_target_o(pred_target_o),
    .skip_update_o(skip_update_o)
  );

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
        finish_run();
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [ADDR_W-1:0] act,
                     input logic [ADDR_W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] ret_of(logic [ADDR_W-1:0] pc, logic [LEN_W-1:0] len);
    return pc + ADDR_W'(len);
  endfunction

  // Drive at negedge, check combinational outputs, then commit the model at posedge.
  task automatic step(input bit c, input bit r, input logic [ADDR_W-1:0] pc,
                      input logic [LEN_W-1:0] len, input string tag);
    bit exp_v;
    logic [ADDR_W-1:0] exp_t;
    @(negedge clk);
    call_i = c; ret_i = r; call_pc_i = pc; insn_len_i = len;
    #1;
    exp_v = r && (model_q.size() != 0);
    exp_t = exp_v ? model_q[model_q.size()-1] : '0;
    chk(skip_update_o == (c | r), "R7 skip flag", ADDR_W'(skip_update_o), ADDR_W'(c | r));
    chk(pred_valid_o == exp_v, {tag, " valid"}, ADDR_W'(pred_valid_o), ADDR_W'(exp_v));
    if (exp_v) chk(pred_target_o == exp_t, {tag, " target"}, pred_target_o, exp_t);
    @(posedge clk);
    if (c && r && model_q.size() != 0) begin
      model_q[model_q.size()-1] = ret_of(pc, len);
    end else if (c) begin
      if (model_q.size() == DEPTH) void'(model_q.pop_front());
      model_q.push_back(ret_of(pc, len));
    end else if (r && model_q.size() != 0) begin
      void'(model_q.pop_back());
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk(pred_valid_o == 1'b0, "R1 reset valid", ADDR_W'(pred_valid_o), '0);
    rst_ni = 1'b1;

    step(0, 1, '0, '0, "R1 ret after reset");
    step(0, 0, '0, '0, "R9 idle");
    // R2 basic push and wrap of address sum
    step(1, 0, 32'h0000_1000, 3'd4, "R2 push");
    step(1, 0, 32'hFFFF_FFFE, 3'd4, "R2 push wrap");
    step(0, 1, '0, '0, "R2 pop wrap value");
    step(0, 1, '0, '0, "R3 pop lifo");
    // R4 empty pop then push still works
    step(0, 1, '0, '0, "R4 empty pop");
    step(1, 0, 32'h0000_2000, 3'd2, "R4 push after empty");
    step(0, 1, '0, '0, "R4 pop after empty");
    // R5 overflow by three, then drain past empty
    for (int i = 0; i < DEPTH + 3; i++)
      step(1, 0, 32'h0001_0000 + 32'(i * 16), 3'd4, "R5 overflow push");
    for (int i = 0; i < DEPTH + 1; i++) step(0, 1, '0, '0, "R5 drain");
    // R6 swap on empty and on full
    step(1, 1, 32'h0000_3000, 3'd4, "R6 swap empty");
    step(0, 1, '0, '0, "R6 pop after empty swap");
    for (int i = 0; i < DEPTH; i++) step(1, 0, 32'h0002_0000 + 32'(i * 8), 3'd2, "R6 fill");
    step(1, 1, 32'h0000_4000, 3'd4, "R6 swap full");
    for (int i = 0; i < DEPTH + 1; i++) step(0, 1, '0, '0, "R6 drain");
    // Random mix: push-heavy then pop-heavy phases
    for (int ph = 0; ph < 2; ph++) begin
      for (int i = 0; i < 2000; i++) begin
        int unsigned sel = $urandom_range(0, 99);
        bit c = (ph == 0) ? (sel < 55) : (sel < 30);
        bit r = (($urandom_range(0, 99)) < ((ph == 0) ? 35 : 60));
        step(c, r, $urandom(), LEN_W'($urandom_range(1, 7)), "R3 random");
      end
    end
    step(0, 0, '0, '0, "R9 final idle");
    finish_run();
  end
endmodule